// File: doc/BRIEF.md
# SHA-256 Block Compression Engine

This block computes the SHA-256 compression function one 512-bit block at a time. A caller streams sixteen 32-bit big-endian message words into it over a valid/ready handshake. Once the sixteenth word is taken, the engine closes its input and runs the 64 rounds, one per clock. It then folds the working variables into a chaining digest and opens its input again for the next block.

Padding is the caller's job: every block it offers must already be a complete 512-bit block. An init pulse returns the chaining digest to the standard SHA-256 initial value, which starts a new message. A swap input selects the byte order of each 32-bit word on the digest output. Swapping only changes the view on the output and never changes the stored digest.

Top module: `sha256_block_engine`

## Requirements
- R1: After reset, and in the cycle after an init pulse, `digest_o` (with `swap_i`=0) equals the SHA-256 initial value 6a09e667 bb67ae85 3c6ef372 a54ff53a 510e527f 9b05688c 1f83d9ab 5be0cd19. H0 sits in bits 255:224. In that cycle `word_ready_o` is 1 and `block_done_o` is 0.
- R2: While loading, `word_ready_o` is 1. A word is taken on each clock edge where `word_valid_i` and `word_ready_o` are both 1. The first word taken is W[0] of the block.
- R3: From the edge that takes the 16th word, `word_ready_o` stays 0 for exactly 64 cycles. Words offered during that time are not taken and do not change the result.
- R4: `block_done_o` is a single-cycle pulse. It is first high 64 clock edges after the edge that took the 16th word, so continuously fed blocks take 80 cycles each. `word_ready_o` is 1 again in that same cycle.
- R5: When `block_done_o` is high, the digest holds the standard SHA-256 compression of the block with the previous digest. Examples: the padded block for "abc" gives ba7816bf…f20015ad, and the padded empty message gives e3b0c442…7852b855.
- R6: The digest left by one block is the chaining value for the next block. A two-block padded message gives its standard hash after the second block.
- R7: An init pulse during loading throws away the words taken so far. The next word taken becomes W[0] of a fresh block, and the digest starts again from the initial value.
- R8: With `swap_i`=1, each 32-bit word of `digest_o` appears with its four bytes reversed. The word positions do not change.
- R9: Idle cycles with `word_valid_i`=0 between words taken during loading do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_i | input | 1 | Restart: load initial hash value, return to loading |
| word_valid_i | input | 1 | Message word offered |
| word_i | input | 32 | Message word, big-endian |
| word_ready_o | output | 1 | Engine takes a word this cycle |
| block_done_o | output | 1 | One-cycle pulse when a block has been folded in |
| swap_i | input | 1 | Reverse bytes of each digest word on output |
| digest_o | output | 256 | Chaining digest, H0 in the top word |

## Verification
The bench floods the input with junk words for the whole round phase. An engine that leaked input during the rounds would corrupt the schedule and produce a wrong digest, or it would take a junk word as the first word of the next block. The bench also measures the gap from the last word taken to the done pulse and the length of the ready-low window; an off-by-one in the round counter shows up there as 63 or 65. A two-block message catches an engine that reseeds from the initial value instead of chaining. An init in the middle of a block catches a load counter that is not cleared. Known-answer digests, sent once with idle gaps and once byte-swapped, catch wrong constants, wrong schedule taps and a wrong byte order.

// File: rtl/sha256_block_engine.sv
module sha256_block_engine #(
  parameter int ROUNDS = 64,
  parameter int WORDS  = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init_i,
  input  logic         word_valid_i,
  input  logic [31:0]  word_i,
  output logic         word_ready_o,
  output logic         block_done_o,
  input  logic         swap_i,
  output logic [255:0] digest_o
);
  localparam int CW = $clog2(ROUNDS);
  localparam logic [CW-1:0] LAST_RND  = CW'(ROUNDS - 1);
  localparam logic [CW-1:0] LAST_WORD = CW'(WORDS - 1);

  localparam logic [255:0] IV = {
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

  localparam logic [2047:0] KTAB = {
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

  typedef enum logic {S_LOAD, S_ROUND} state_t;

  function automatic logic [31:0] rotr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  state_t        state;
  logic [CW-1:0] cnt;
  logic [255:0]  hv;
  logic [31:0]   w [WORDS];
  logic [31:0]   a, b, c, d, e, f, g, h;

  logic        accept, last_word, last_rnd, shift_en;
  logic [31:0] k_t, sg0, sg1, w_new, big0, big1, ch, maj, t1, t2;
  logic [255:0] hv_sum;

  assign word_ready_o = (state == S_LOAD);
  assign accept    = word_valid_i && word_ready_o;
  assign last_word = accept && (cnt == LAST_WORD);
  assign last_rnd  = (state == S_ROUND) && (cnt == LAST_RND);
  assign shift_en  = accept || (state == S_ROUND);

  assign k_t   = KTAB[(ROUNDS - 1 - int'(cnt)) * 32 +: 32];
  assign sg0   = rotr(w[1], 7) ^ rotr(w[1], 18) ^ (w[1] >> 3);
  assign sg1   = rotr(w[14], 17) ^ rotr(w[14], 19) ^ (w[14] >> 10);
  assign w_new = sg1 + w[9] + sg0 + w[0];

  assign big1 = rotr(e, 6) ^ rotr(e, 11) ^ rotr(e, 25);
  assign big0 = rotr(a, 2) ^ rotr(a, 13) ^ rotr(a, 22);
  assign ch   = (e & f) ^ (~e & g);
  assign maj  = (a & b) ^ (a & c) ^ (b & c);
  assign t1   = h + big1 + ch + k_t + w[0];
  assign t2   = big0 + maj;

  assign hv_sum = {hv[255:224] + t1 + t2, hv[223:192] + a, hv[191:160] + b, hv[159:128] + c,
                   hv[127:96] + d + t1,   hv[95:64] + e,   hv[63:32] + f,    hv[31:0] + g};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_LOAD;
      cnt          <= '0;
      hv           <= IV;
      block_done_o <= 1'b0;
    end else begin
      block_done_o <= 1'b0;
      if (init_i) begin
        state <= S_LOAD;
        cnt   <= '0;
        hv    <= IV;
      end else if (state == S_LOAD) begin
        if (accept) begin
          cnt <= last_word ? '0 : cnt + 1'b1;
          if (last_word) state <= S_ROUND;
        end
      end else begin
        cnt <= cnt + 1'b1;
        if (last_rnd) begin
          state        <= S_LOAD;
          cnt          <= '0;
          hv           <= hv_sum;
          block_done_o <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (shift_en) begin
      for (int i = 0; i < WORDS - 1; i++) w[i] <= w[i + 1];
      w[WORDS - 1] <= accept ? word_i : w_new;
    end
  end

  always_ff @(posedge clk) begin
    if (last_word && !init_i) begin
      {a, b, c, d, e, f, g, h} <= hv;
    end else if (state == S_ROUND) begin
      a <= t1 + t2; b <= a; c <= b; d <= c;
      e <= d + t1;  f <= e; g <= f; h <= g;
    end
  end

  for (genvar gi = 0; gi < 8; gi++) begin : g_out
    logic [31:0] wd;
    assign wd = hv[gi*32 +: 32];
    assign digest_o[gi*32 +: 32] = swap_i ? {wd[7:0], wd[15:8], wd[23:16], wd[31:24]} : wd;
  end

  p_init_iv_r1: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (hv == IV && word_ready_o));

  p_ready_at_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    block_done_o |-> word_ready_o);

  p_close_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (last_word && !init_i) |=> !word_ready_o);

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    block_done_o |=> !block_done_o);

  p_chain_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && !last_rnd) |=> $stable(hv));
endmodule

// File: tb/test_sha256_block_engine.sv
module test_sha256_block_engine;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         init_i = 0;
  logic         word_valid_i = 0;
  logic [31:0]  word_i = '0;
  logic         word_ready_o;
  logic         block_done_o;
  logic         swap_i = 0;
  logic [255:0] digest_o;

  always #4 clk = ~clk;

  sha256_block_engine i_sha256_block_engine (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .word_valid_i(word_valid_i),
    .word_i(word_i), .word_ready_o(word_ready_o), .block_done_o(block_done_o),
    .swap_i(swap_i), .digest_o(digest_o));

  localparam logic [255:0] IV    = 256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19;
  localparam logic [255:0] D_ABC = 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad;
  localparam logic [255:0] D_NIL = 256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855;
  localparam logic [255:0] D_TWO = 256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1;

  typedef struct { bit chk; logic [255:0] exp; string tag; } item_t;
  item_t q[$];

  int vectors = 0, fails = 0;
  int cyc = 0, t_last = 0, low_run = 0;
  logic [31:0] blk [16];

  task automatic check(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] bswap(input logic [255:0] x);
    logic [255:0] r;
    for (int i = 0; i < 8; i++) begin
      logic [31:0] v;
      v = x[i*32 +: 32];
      r[i*32 +: 32] = {v[7:0], v[15:8], v[23:16], v[31:24]};
    end
    return r;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (block_done_o) begin
        if (q.size() == 0) check(0, "R4 unexpected done", 256'(cyc), 256'(0));
        else begin
          item_t it;
          it = q.pop_front();
          check(cyc - t_last == 65, "R4 done latency", 256'(cyc - t_last), 256'(65));
          check(low_run == 64, "R3 ready-low window", 256'(low_run), 256'(64));
          check(word_ready_o == 1, "R2 ready at done", 256'(word_ready_o), 256'(1));
          if (it.chk) check(digest_o == it.exp, it.tag, digest_o, it.exp);
        end
      end
      low_run = word_ready_o ? 0 : low_run + 1;
    end
  end

  task automatic send_word(input logic [31:0] wd, input int gap);
    repeat (gap) begin @(negedge clk); word_valid_i = 0; end
    @(negedge clk);
    word_valid_i = 1;
    word_i = wd;
    forever begin
      bit acc;
      acc = word_ready_o;
      @(posedge clk);
      if (acc) break;
      @(negedge clk);
    end
  endtask

  task automatic run_block(input bit chk, input logic [255:0] exp, input string tag, input int gap);
    item_t it;
    it.chk = chk; it.exp = exp; it.tag = tag;
    for (int i = 0; i < 16; i++) begin
      send_word(blk[i], (i % 3 == 1) ? gap : 0);
      if (i == 15) begin
        t_last = cyc;
        q.push_back(it);
      end
    end
    @(negedge clk);
    word_valid_i = 1;
    word_i = 32'hdeadbeef;
    while (!word_ready_o) begin
      word_i = word_i + 32'h01010101;
      @(negedge clk);
    end
    word_valid_i = 0;
  endtask

  task automatic pulse_init();
    @(negedge clk);
    init_i = 1;
    @(negedge clk);
    init_i = 0;
    check(digest_o == (swap_i ? bswap(IV) : IV), "R1/R7 digest after init", digest_o, IV);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic fill_abc();
    for (int i = 0; i < 16; i++) blk[i] = '0;
    blk[0] = 32'h61626380; blk[15] = 32'h00000018;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(digest_o == IV, "R1 reset digest", digest_o, IV);
    check(word_ready_o == 1 && block_done_o == 0, "R1 reset ready/done",
          256'({word_ready_o, block_done_o}), 256'(2'b10));

    fill_abc();
    run_block(1, D_ABC, "R5 abc digest", 0);
    drain();

    pulse_init();
    for (int i = 0; i < 16; i++) blk[i] = '0;
    blk[0] = 32'h80000000;
    run_block(1, D_NIL, "R9 empty digest with idle gaps", 3);
    drain();

    pulse_init();
    for (int i = 0; i < 14; i++) blk[i] = {8'h61 + 8'(i), 8'h62 + 8'(i), 8'h63 + 8'(i), 8'h64 + 8'(i)};
    blk[14] = 32'h80000000; blk[15] = 32'h0;
    run_block(0, '0, "R6 first block", 0);
    for (int i = 0; i < 16; i++) blk[i] = '0;
    blk[15] = 32'h000001c0;
    run_block(1, D_TWO, "R6 two-block chained digest", 0);
    drain();

    pulse_init();
    for (int i = 0; i < 5; i++) send_word(32'h12345678 + i, 0);
    @(negedge clk); word_valid_i = 0;
    pulse_init();
    fill_abc();
    run_block(1, D_ABC, "R7 abc after mid-load init", 1);
    drain();

    swap_i = 1;
    @(negedge clk);
    check(digest_o == bswap(D_ABC), "R8 swapped view of stored digest", digest_o, bswap(D_ABC));
    swap_i = 0;
    @(negedge clk);
    check(digest_o == D_ABC, "R8 swap leaves stored digest intact", digest_o, D_ABC);
    swap_i = 1;
    pulse_init();
    fill_abc();
    run_block(1, bswap(D_ABC), "R8 swapped abc digest", 0);
    drain();

    finish_run();
  end
endmodule